// File: doc/BRIEF.md
# Signed Sequential Add-Shift Multiplier

This block multiplies two signed two's complement operands of `W` bits (default 4) and returns a signed product of `2W` bits. It works in steps, one multiplier bit per clock. An accumulator of `2W+1` bits holds the running partial product in its upper `W+1` bits and the multiplier bits that remain in its lower `W` bits. The bit at the bottom of the accumulator decides whether the multiplicand joins the partial product. The adder result goes into the accumulator one place to the right, so the add and the arithmetic right shift happen in the same clock.

On the last step a set multiplier sign bit means the multiplicand has negative weight, so it is subtracted instead of added. A step counter separate from the control raises a last-step flag, and that flag ends the run. The guard bit at the top keeps the sign of the partial product when an add carries past `W` bits.

The user drives the operands and raises `go`. After `W+1` clocks `done` pulses for one cycle and `product` holds the result until the next operation starts.

Top module: `tcm_seq_mult`

## Requirements
- R1: While reset is applied and after it is released, `done` is 0 and `product` is 0 until the first operation finishes.
- R2: An operation starts only on a clock where `go` is 1 and was 0 on the previous clock, and only while the block is idle. Holding `go` high starts exactly one operation.
- R3: If the start clock is edge 0, `done` is 1 in the cycle after edge `W`, which is `W+1` clocks after the start.
- R4: When `done` is 1, `product` is the signed `2W`-bit product of the signed operands sampled at the start clock, for every pair of operand values.
- R5: The pairs 7×5=35, (−3)×5=−15, 5×(−3)=−15 and (−5)×(−3)=15 give those values (4-bit operands, codes 0111, 1101, 0101 and 1011).
- R6: Outside a running operation, `product` keeps its value until the next start, even when the operand inputs change.
- R7: A new rising `go` during a running operation is ignored. The result is unchanged and no extra `done` pulse appears.
- R8: `done` is high for exactly one cycle per operation.
- R9: The extreme operands are correct: (−8)×(−8)=64, (−8)×7=−56 and 7×7=49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| go | input | 1 | Start request, acted on at its rising edge |
| multiplicand | input | W | Signed multiplicand |
| multiplier | input | W | Signed multiplier |
| product | output | 2W | Signed product, read when `done` is 1 |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong accumulator bit, a missing sign extension on the shift, or a wrong last-step correction shows up as a wrong `product` at the very next `done` pulse. The full sweep of all operand pairs exposes it wherever it appears. A step counter that is off by one moves the `done` pulse away from clock `W+1` and damages the product, so the latency check and the value check both catch it in the first operation. A fault in the start-edge or idle gating shows up as a `done` pulse with no request behind it, within `W+1` clocks of the unwanted start.

// File: rtl/tcm_mult_pkg.sv
package tcm_mult_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;
endpackage

// File: rtl/tcm_step_cnt.sv
module tcm_step_cnt #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || adv) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_mult_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic last,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  phase_t ph_q, ph_d;
  logic   go_q;

  assign load = go && !go_q && (ph_q == PH_IDLE);
  assign step = (ph_q == PH_RUN);
  assign busy = step;
  assign done = (ph_q == PH_FIN);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (load) ph_d = PH_RUN;
      PH_RUN:  if (last) ph_d = PH_FIN;
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      go_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      go_q <= go;
    end
  end
endmodule

// File: rtl/tcm_datapath.sv
module tcm_datapath #(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             last,
  input  logic [W-1:0]     mcand_in,
  input  logic [W-1:0]     mplier_in,
  output logic [2*W-1:0]   prod
);
  localparam int AW = 2 * W + 1;

  logic [AW-1:0]   acc_q, acc_d;
  logic [W-1:0]    mc_q;
  logic signed [W:0] mc_ext, addend, upper, sum;

  assign mc_ext = {mc_q[W-1], mc_q};
  assign upper  = acc_q[AW-1:W];

  always_comb begin
    addend = '0;
    if (acc_q[0]) addend = last ? -mc_ext : mc_ext;
    sum = upper + addend;
  end

  always_comb begin
    acc_d = acc_q;
    if (load)      acc_d = {{(W + 1){1'b0}}, mplier_in};
    else if (step) acc_d = {sum[W], sum, acc_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc_q <= '0;
    else if (load || step) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mc_q <= '0;
    else if (load) mc_q <= mcand_in;
  end

  assign prod = acc_q[2*W-1:0];
endmodule

// File: rtl/tcm_seq_mult.sv
module tcm_seq_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic rst_m, rst_sync;
  logic load_w, step_w, last_w, busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m    <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_m    <= 1'b1;
      rst_sync <= rst_m;
    end
  end

  tcm_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync),
    .go    (go),
    .last  (last_w),
    .load  (load_w),
    .step  (step_w),
    .busy  (busy_w),
    .done  (done)
  );

  tcm_step_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync),
    .clr   (load_w),
    .adv   (step_w),
    .last  (last_w)
  );

  tcm_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync),
    .load      (load_w),
    .step      (step_w),
    .last      (last_w),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .prod      (product)
  );
endmodule

// File: rtl/tcm_seq_mult_chk.sv
module tcm_seq_mult_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic [2*W-1:0] product
);
  localparam int W2 = 2 * W;
  localparam int LW = $clog2(W + 3);

  logic [LW:0]   lat_q;
  logic [W2-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      exp_q <= '0;
    end else begin
      if (start) begin
        lat_q <= (LW + 1)'(1);
        exp_q <= W2'(signed'(mcand)) * W2'(signed'(mplier));
      end else if (lat_q != '0 && lat_q < (LW + 1)'(W + 2)) begin
        lat_q <= lat_q + (LW + 1)'(1);
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (LW + 1)'(W + 1)));

  // R3
  latency_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q == (LW + 1)'(W + 1)) |-> done);

  // R4
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

bind tcm_seq_mult tcm_seq_mult_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync),
  .start   (load_w),
  .busy    (busy_w),
  .done    (done),
  .mcand   (multiplicand),
  .mplier  (multiplier),
  .product (product)
);

// File: tb/tcm_seq_mult_test.sv
`timescale 1ns/1ps
module tcm_seq_mult_test;
  localparam int W  = 4;
  localparam int W2 = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          go;
  logic [W-1:0]  multiplicand, multiplier;
  logic [W2-1:0] product;
  logic          done;

  int tests = 0;
  int fails = 0;
  logic [W2-1:0] sb_q[$];
  logic          prev_done = 1'b0;

  always #2 clk = ~clk;

  tcm_seq_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .go(go),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse (R4, R5, R9, R8, R2, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(0, "R8 done longer than one cycle", 2, 1);
      if (done) begin
        if (sb_q.size() == 0) begin
          check(0, "R2/R7 unrequested done", 1, 0);
        end else begin
          logic [W2-1:0] e;
          e = sb_q.pop_front();
          check(product == e, "R4 product", longint'($signed(product)), longint'($signed(e)));
        end
      end
    end
    prev_done <= done;
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit hold, input bit mid);
    int n;
    sb_q.push_back(W2'(signed'(a)) * W2'(signed'(b)));
    @(negedge clk);
    multiplicand = a; multiplier = b; go = 1'b1; n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1)      go = hold;
      else if (n == 2) go = hold | mid;
      else if (n == 3) go = hold;
    end while (!done && n < 50);
    if (!hold) go = 1'b0;
    check(n == W + 1, "R3 latency", n, W + 1);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W2-1:0] held;
    rst_n = 1'b0; go = 1'b0; multiplicand = '0; multiplier = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(product == '0, "R1 product in reset", product, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);

    // R5 worked examples
    run_op(4'b0111, 4'b0101, 0, 0);
    check($signed(product) == 35, "R5 7x5", longint'($signed(product)), 35);
    run_op(4'b1101, 4'b0101, 0, 0);
    check($signed(product) == -15, "R5 -3x5", longint'($signed(product)), -15);
    run_op(4'b0101, 4'b1101, 0, 0);
    check($signed(product) == -15, "R5 5x-3", longint'($signed(product)), -15);
    run_op(4'b1011, 4'b1101, 0, 0);
    check($signed(product) == 15, "R5 -5x-3", longint'($signed(product)), 15);

    // R9 extremes
    run_op(4'b1000, 4'b1000, 0, 0);
    check($signed(product) == 64, "R9 -8x-8", longint'($signed(product)), 64);
    run_op(4'b1000, 4'b0111, 0, 0);
    check($signed(product) == -56, "R9 -8x7", longint'($signed(product)), -56);
    run_op(4'b0111, 4'b0111, 0, 0);
    check($signed(product) == 49, "R9 7x7", longint'($signed(product)), 49);

    // R6 product held while idle, operand inputs moving
    held = product;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      multiplicand = W'(k * 3); multiplier = W'(k + 5);
    end
    check(product == held, "R6 product hold", longint'(product), longint'(held));

    // R2 go held high: one operation only
    run_op(4'b0011, 4'b1110, 1, 0);
    repeat (12) @(negedge clk);
    go = 1'b0;
    check(sb_q.size() == 0, "R2 held go single result", sb_q.size(), 0);

    // R7 second rising go mid-run is ignored
    run_op(4'b1010, 4'b0110, 0, 1);
    repeat (10) @(negedge clk);
    check($signed(product) == -36, "R7 mid-run restart ignored", longint'($signed(product)), -36);

    // R4 full sweep
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        run_op(W'(i), W'(j), 0, 0);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule